// File: doc/BRIEF.md
# Flash Command State Machine

This block is the command front end of a NOR-style page flash. A host writes 8-bit command codes on the low byte of the data bus. The block follows the one-cycle and two-cycle command sequences, sets the read mode that the array path uses, and starts program, erase, lock and protection-register operations on a separate write engine. It also handles suspend and resume of a running program or erase, and keeps a status byte whose ready bit follows the write engine.

Writes are synchronous strobes that carry an address and a data word. The engine reports that it has finished with a one-cycle done pulse. Each operation request is a one-cycle pulse that carries the operation kind, the address and the data word of the write that triggered it. The status byte seen by the host is captured at the start of each read, so it cannot change in the middle of that read.

Status bit map: bit 7 is ready, bit 6 is erase suspended, bit 5 is the erase-side error, bit 4 is the program-side error, bit 2 is program suspended, and bits 3, 1 and 0 always read zero. Read-mode encoding: 0 array, 1 identifier, 2 status, 3 query.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, rd_mode is 0 (array), the status byte is 80h, op_req is low and status_q reads 80h.
- R2: When idle, code FFh sets rd_mode 0, 90h sets 1, 70h sets 2 and 98h sets 3. The new mode appears in the cycle after the write.
- R3: Code 20h followed by D0h pulses op_req with op_kind 2 (erase) and the address and data of the second write. The block then reports status mode 2 and clears ready (bit 7).
- R4: Code 40h or 10h followed by any word pulses op_req with op_kind 1 (program), carrying the second write's address and data, and clears ready.
- R5: After prefix 60h, a second byte of 01h requests op_kind 3 (lock), D0h requests op_kind 4 (unlock) and 2Fh requests op_kind 5 (lock-down).
- R6: After prefix C0h, a second write of FFFDh at address PREG_LOCK_ADDR requests op_kind 7 (protection lock). Any other second write requests op_kind 6 (protection program).
- R7: A second byte after 20h other than D0h, or after 60h other than 01h, D0h or 2Fh, sets status bits 5 and 4, selects status mode and issues no request. Code 50h in the idle state clears bits 5 and 4 and leaves the read mode unchanged.
- R8: While an operation runs, every write other than B0h during a program or erase is ignored: there is no request and no change of mode or status. During a lock or protection operation, B0h is ignored as well.
- R9: B0h during a running program or erase requests op_kind 8 (suspend) and sets ready. It also sets bit 2 (program) or bit 6 (erase). D0h while suspended requests op_kind 9 (resume), clears ready and the suspend bit, and selects status mode.
- R10: While suspended, the read-mode codes of R2 are accepted. All other codes except D0h are ignored, and a done pulse has no effect.
- R11: A done pulse while an operation runs sets ready. The full command set is then accepted again, and the read mode stays at status.
- R12: status_q captures the status byte in the cycle rd_en rises and holds it while rd_en stays high, even if the status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command/data write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the low byte is the command code |
| rd_en | input | 1 | Read strobe; its rising edge captures the status |
| eng_done | input | 1 | Write engine finished pulse |
| rd_mode | output | 2 | Selected read mode |
| op_req | output | 1 | One-cycle operation request |
| op_kind | output | 4 | Requested operation kind |
| op_addr | output | ADDR_W | Address of the request |
| op_data | output | DATA_W | Data of the request |
| status_q | output | 8 | Status byte captured at the start of the read |

## Verification
The bench goes after the shared prefix codes. A decoder that mixed up the second byte after 60h, or treated D0h after 20h like D0h after 60h, would report the wrong op_kind. It also drives writes of every kind while an operation runs and while it is suspended; a block that leaked commands through would change the mode or raise a request. The protection lock path is tested with FFFDh at the wrong address, which must give a protection program instead. The status capture is tested by starting an erase while rd_en is held high; a latch that follows its input would drop the ready bit in the middle of the read.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_IDENT = 2'd1, RM_STATUS = 2'd2, RM_QUERY = 2'd3} rd_mode_e;

  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_PROG = 4'd1, OP_ERASE = 4'd2, OP_LOCK = 4'd3, OP_UNLOCK = 4'd4,
    OP_LOCKDN = 4'd5, OP_PREG_PROG = 4'd6, OP_PREG_LOCK = 4'd7, OP_SUSPEND = 4'd8, OP_RESUME = 4'd9
  } op_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SET_ERASE, ST_SET_PROG, ST_SET_LOCK, ST_SET_PREG,
    ST_RUN_PROG, ST_RUN_ERASE, ST_RUN_MISC, ST_SUS_PROG, ST_SUS_ERASE
  } cmd_st_e;

  localparam int SR_READY = 7;
  localparam int SR_ESUS  = 6;
  localparam int SR_ERR_E = 5;
  localparam int SR_ERR_P = 4;
  localparam int SR_PSUS  = 2;
  localparam logic [7:0] SR_RESET = 8'h80;

  typedef struct packed {
    logic       rd_sel;
    logic [1:0] rd_mode;
    logic       clr;
    logic       setup_erase;
    logic       setup_prog;
    logic       setup_lock;
    logic       setup_preg;
    logic       suspend;
    logic       confirm;
    logic       lock_ok;
    logic [3:0] lock_kind;
  } cmd_dec_t;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code,
  output cmd_dec_t          dec
);
  always_comb begin
    dec = '0;
    unique case (code)
      8'hFF: begin dec.rd_sel = 1'b1; dec.rd_mode = RM_ARRAY;  end
      8'h90: begin dec.rd_sel = 1'b1; dec.rd_mode = RM_IDENT;  end
      8'h70: begin dec.rd_sel = 1'b1; dec.rd_mode = RM_STATUS; end
      8'h98: begin dec.rd_sel = 1'b1; dec.rd_mode = RM_QUERY;  end
      8'h50: dec.clr = 1'b1;
      8'h20: dec.setup_erase = 1'b1;
      8'h40, 8'h10: dec.setup_prog = 1'b1;
      8'h60: dec.setup_lock = 1'b1;
      8'hC0: dec.setup_preg = 1'b1;
      8'hB0: dec.suspend = 1'b1;
      default: ;
    endcase
    dec.confirm = (code == 8'hD0);
    // second byte after the lock prefix
    unique case (code)
      8'h01:   begin dec.lock_ok = 1'b1; dec.lock_kind = OP_LOCK;   end
      8'hD0:   begin dec.lock_ok = 1'b1; dec.lock_kind = OP_UNLOCK; end
      8'h2F:   begin dec.lock_ok = 1'b1; dec.lock_kind = OP_LOCKDN; end
      default: dec.lock_kind = OP_NONE;
    endcase
  end
endmodule

// File: rtl/flash_status_latch.sv
module flash_status_latch #(
  parameter int SR_W = 8,
  parameter logic [SR_W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [SR_W-1:0] status_in,
  output logic [SR_W-1:0] status_q
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      status_q <= RST_VAL;
    end else begin
      rd_q <= rd_en;
      if (rd_en && !rd_q) status_q <= status_in;
    end
  end

  // R12: value held for the whole read
  p_hold_read_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_q) |=> $stable(status_q));
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] PREG_LOCK_ADDR = 'h80,
  parameter logic [DATA_W-1:0] PREG_LOCK_DATA = 'hFFFD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              eng_done,
  output logic [1:0]        rd_mode,
  output logic              op_req,
  output logic [3:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [7:0]        status_q
);
  localparam int CODE_W = 8;

  cmd_dec_t   dec;
  cmd_st_e    st, st_n;
  logic [1:0] mode_n;
  logic [7:0] sr, sr_n;
  logic       req_n, launch, seq_err;
  logic [3:0] kind_n, launch_kind;
  cmd_st_e    launch_st;

  flash_cmd_decode #(.CODE_W(CODE_W)) u_dec (.code(wr_data[CODE_W-1:0]), .dec(dec));

  flash_status_latch #(.SR_W(8), .RST_VAL(SR_RESET)) u_sts (
    .clk(clk), .rst(rst), .rd_en(rd_en), .status_in(sr), .status_q(status_q)
  );

  always_comb begin
    st_n = st; mode_n = rd_mode; sr_n = sr;
    req_n = 1'b0; kind_n = op_kind;
    launch = 1'b0; launch_kind = OP_NONE; launch_st = ST_IDLE; seq_err = 1'b0;
    case (st)
      ST_IDLE: if (wr_en) begin
        if (dec.rd_sel) mode_n = dec.rd_mode;
        else if (dec.clr) begin sr_n[SR_ERR_E] = 1'b0; sr_n[SR_ERR_P] = 1'b0; end
        else if (dec.setup_erase) begin st_n = ST_SET_ERASE; mode_n = RM_STATUS; end
        else if (dec.setup_prog)  begin st_n = ST_SET_PROG;  mode_n = RM_STATUS; end
        else if (dec.setup_lock)  begin st_n = ST_SET_LOCK;  mode_n = RM_STATUS; end
        else if (dec.setup_preg)  begin st_n = ST_SET_PREG;  mode_n = RM_STATUS; end
      end
      ST_SET_ERASE: if (wr_en) begin
        if (dec.confirm) begin launch = 1'b1; launch_kind = OP_ERASE; launch_st = ST_RUN_ERASE; end
        else seq_err = 1'b1;
      end
      ST_SET_PROG: if (wr_en) begin
        launch = 1'b1; launch_kind = OP_PROG; launch_st = ST_RUN_PROG;
      end
      ST_SET_LOCK: if (wr_en) begin
        if (dec.lock_ok) begin launch = 1'b1; launch_kind = dec.lock_kind; launch_st = ST_RUN_MISC; end
        else seq_err = 1'b1;
      end
      ST_SET_PREG: if (wr_en) begin
        launch = 1'b1; launch_st = ST_RUN_MISC;
        launch_kind = (wr_addr == PREG_LOCK_ADDR && wr_data == PREG_LOCK_DATA) ? OP_PREG_LOCK : OP_PREG_PROG;
      end
      ST_RUN_PROG, ST_RUN_ERASE: begin
        if (eng_done) begin sr_n[SR_READY] = 1'b1; st_n = ST_IDLE; end
        else if (wr_en && dec.suspend) begin
          req_n = 1'b1; kind_n = OP_SUSPEND; sr_n[SR_READY] = 1'b1; mode_n = RM_STATUS;
          if (st == ST_RUN_PROG) begin sr_n[SR_PSUS] = 1'b1; st_n = ST_SUS_PROG; end
          else begin sr_n[SR_ESUS] = 1'b1; st_n = ST_SUS_ERASE; end
        end
      end
      ST_RUN_MISC: if (eng_done) begin sr_n[SR_READY] = 1'b1; st_n = ST_IDLE; end
      ST_SUS_PROG, ST_SUS_ERASE: if (wr_en) begin
        if (dec.rd_sel) mode_n = dec.rd_mode;
        else if (dec.confirm) begin
          req_n = 1'b1; kind_n = OP_RESUME; sr_n[SR_READY] = 1'b0; mode_n = RM_STATUS;
          if (st == ST_SUS_PROG) begin sr_n[SR_PSUS] = 1'b0; st_n = ST_RUN_PROG; end
          else begin sr_n[SR_ESUS] = 1'b0; st_n = ST_RUN_ERASE; end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (launch) begin
      req_n = 1'b1; kind_n = launch_kind; st_n = launch_st;
      sr_n[SR_READY] = 1'b0; mode_n = RM_STATUS;
    end
    if (seq_err) begin
      sr_n[SR_ERR_E] = 1'b1; sr_n[SR_ERR_P] = 1'b1; st_n = ST_IDLE; mode_n = RM_STATUS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; rd_mode <= RM_ARRAY; sr <= SR_RESET;
      op_req <= 1'b0; op_kind <= OP_NONE; op_addr <= '0; op_data <= '0;
    end else begin
      st <= st_n; rd_mode <= mode_n; sr <= sr_n;
      op_req <= req_n; op_kind <= kind_n;
      if (req_n) begin op_addr <= wr_addr; op_data <= wr_data; end
    end
  end

  // R3: an operation in progress never reports ready
  p_busy_not_ready_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN_PROG || st == ST_RUN_ERASE || st == ST_RUN_MISC) |-> !sr[SR_READY]);
  // R7: bad confirm after the erase prefix
  p_seq_err_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SET_ERASE && wr_en && wr_data[7:0] != 8'hD0) |=> (sr[SR_ERR_E] && sr[SR_ERR_P] && rd_mode == RM_STATUS && !op_req));
  // R8: lock/protection operations cannot be suspended
  p_misc_no_req_r8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN_MISC) |=> !op_req);
  // R9: suspend of a program
  p_prog_susp_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN_PROG && wr_en && wr_data[7:0] == 8'hB0 && !eng_done) |=> (sr[SR_PSUS] && sr[SR_READY] && op_req));
  // R11: done returns to idle with ready set
  p_done_ready_r11: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RUN_PROG || st == ST_RUN_ERASE || st == ST_RUN_MISC) && eng_done) |=> (sr[SR_READY] && st == ST_IDLE));
endmodule

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam logic [AW-1:0] LOCK_A = 21'h80;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, eng_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] rd_mode;
  logic op_req;
  logic [3:0] op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [7:0] status_q;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  flash_cmd_fsm u_flash_cmd_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .eng_done(eng_done), .rd_mode(rd_mode), .op_req(op_req),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .status_q(status_q)
  );

  // behavioural reference: state 0 idle, 1-4 waiting for second write,
  // 5 program running, 6 erase running, 7 other running, 8/9 program/erase suspended
  int m_st;
  logic [1:0] m_mode;
  logic [7:0] m_sr, m_q;
  logic m_req, m_prev_rd;
  logic [3:0] m_kind;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  task automatic m_go(input int k, input int ns);
    m_req = 1'b1; m_kind = 4'(k); m_addr = wr_addr; m_data = wr_data;
    m_st = ns; m_sr[7] = 1'b0; m_mode = 2'd2;
  endtask

  task automatic m_err();
    m_sr = m_sr | 8'h30; m_st = 0; m_mode = 2'd2;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_mode = 0; m_sr = 8'h80; m_q = 8'h80; m_req = 0; m_kind = 0;
      m_addr = '0; m_data = '0; m_prev_rd = 0;
    end else begin
      logic [7:0] c;
      c = wr_data[7:0];
      if (rd_en && !m_prev_rd) m_q = m_sr;
      m_prev_rd = rd_en;
      m_req = 1'b0;
      if (m_st == 0 && wr_en) begin
        if (c == 8'hFF) m_mode = 0;
        else if (c == 8'h90) m_mode = 1;
        else if (c == 8'h70) m_mode = 2;
        else if (c == 8'h98) m_mode = 3;
        else if (c == 8'h50) m_sr = m_sr & 8'hCF;
        else if (c == 8'h20) begin m_st = 1; m_mode = 2; end
        else if (c == 8'h40 || c == 8'h10) begin m_st = 2; m_mode = 2; end
        else if (c == 8'h60) begin m_st = 3; m_mode = 2; end
        else if (c == 8'hC0) begin m_st = 4; m_mode = 2; end
      end else if (m_st == 1 && wr_en) begin
        if (c == 8'hD0) m_go(2, 6); else m_err();
      end else if (m_st == 2 && wr_en) begin
        m_go(1, 5);
      end else if (m_st == 3 && wr_en) begin
        if (c == 8'h01) m_go(3, 7);
        else if (c == 8'hD0) m_go(4, 7);
        else if (c == 8'h2F) m_go(5, 7);
        else m_err();
      end else if (m_st == 4 && wr_en) begin
        if (wr_addr == LOCK_A && wr_data == 16'hFFFD) m_go(7, 7); else m_go(6, 7);
      end else if (m_st >= 5 && m_st <= 7 && eng_done) begin
        m_sr[7] = 1'b1; m_st = 0;
      end else if ((m_st == 5 || m_st == 6) && wr_en && c == 8'hB0) begin
        m_req = 1; m_kind = 8; m_addr = wr_addr; m_data = wr_data; m_sr[7] = 1; m_mode = 2;
        if (m_st == 5) begin m_sr[2] = 1; m_st = 8; end else begin m_sr[6] = 1; m_st = 9; end
      end else if ((m_st == 8 || m_st == 9) && wr_en) begin
        if (c == 8'hFF) m_mode = 0;
        else if (c == 8'h90) m_mode = 1;
        else if (c == 8'h70) m_mode = 2;
        else if (c == 8'h98) m_mode = 3;
        else if (c == 8'hD0) begin
          m_req = 1; m_kind = 9; m_addr = wr_addr; m_data = wr_data; m_sr[7] = 0; m_mode = 2;
          if (m_st == 8) begin m_sr[2] = 0; m_st = 5; end else begin m_sr[6] = 0; m_st = 6; end
        end
      end
    end
  end

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "model rd_mode", 32'(rd_mode), 32'(m_mode));
      chk(cur_req, "model op_req", 32'(op_req), 32'(m_req));
      chk(cur_req, "model status_q", 32'(status_q), 32'(m_q));
      if (op_req) begin
        chk(cur_req, "model op_kind", 32'(op_kind), 32'(m_kind));
        chk(cur_req, "model op_addr", 32'(op_addr), 32'(m_addr));
        chk(cur_req, "model op_data", 32'(op_data), 32'(m_data));
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic done();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "reset mode", 32'(rd_mode), 0);
    chk("R1", "reset req", 32'(op_req), 0);
    rd(); chk("R1", "reset status", 32'(status_q), 32'h80);

    cur_req = "R2";
    wr(0, 16'h0090); chk("R2", "ident mode", 32'(rd_mode), 1);
    wr(0, 16'h0098); chk("R2", "query mode", 32'(rd_mode), 3);
    wr(0, 16'h0070); chk("R2", "status mode", 32'(rd_mode), 2);
    wr(0, 16'h00FF); chk("R2", "array mode", 32'(rd_mode), 0);

    cur_req = "R4";
    wr(21'h123, 16'h0040); wr(21'h123, 16'hBEEF);
    chk("R4", "prog req", 32'(op_req), 1);
    chk("R4", "prog kind", 32'(op_kind), 1);
    chk("R4", "prog data", 32'(op_data), 32'hBEEF);
    cur_req = "R8";
    wr(0, 16'h00FF); chk("R8", "busy ignores FF", 32'(rd_mode), 2);
    wr(0, 16'h0020); chk("R8", "busy no req", 32'(op_req), 0);
    rd(); chk("R8", "busy status", 32'(status_q), 32'h00);
    cur_req = "R11";
    done(); rd(); chk("R11", "ready after done", 32'(status_q), 32'h80);
    chk("R11", "mode stays status", 32'(rd_mode), 2);
    cur_req = "R4";
    wr(21'h55, 16'h0010); wr(21'h55, 16'h1234);
    chk("R4", "alt prog kind", 32'(op_kind), 1);
    done();

    cur_req = "R3";
    wr(21'h4000, 16'h0020); wr(21'h4001, 16'h00D0);
    chk("R3", "erase kind", 32'(op_kind), 2);
    chk("R3", "erase addr", 32'(op_addr), 32'h4001);
    cur_req = "R9";
    wr(0, 16'h00B0); chk("R9", "suspend kind", 32'(op_kind), 8);
    rd(); chk("R9", "erase suspended status", 32'(status_q), 32'hC0);
    cur_req = "R10";
    wr(0, 16'h0090); chk("R10", "mode while suspended", 32'(rd_mode), 1);
    wr(0, 16'h0040); chk("R10", "prog ignored while suspended", 32'(op_req), 0);
    done(); rd(); chk("R10", "done ignored while suspended", 32'(status_q), 32'hC0);
    cur_req = "R9";
    wr(0, 16'h00D0); chk("R9", "resume kind", 32'(op_kind), 9);
    chk("R9", "resume mode", 32'(rd_mode), 2);
    rd(); chk("R9", "resumed status", 32'(status_q), 32'h00);
    done();
    wr(0, 16'h0040); wr(21'h9, 16'h0);
    wr(0, 16'h00B0); rd(); chk("R9", "program suspended status", 32'(status_q), 32'h84);
    wr(0, 16'h00D0); done();

    cur_req = "R5";
    wr(21'h8000, 16'h0060); wr(21'h8000, 16'h0001); chk("R5", "lock", 32'(op_kind), 3);
    cur_req = "R8";
    wr(0, 16'h00B0); chk("R8", "no suspend of lock", 32'(op_req), 0);
    done();
    cur_req = "R5";
    wr(21'h8000, 16'h0060); wr(21'h8000, 16'h00D0); chk("R5", "unlock", 32'(op_kind), 4); done();
    wr(21'h8000, 16'h0060); wr(21'h8000, 16'h002F); chk("R5", "lock-down", 32'(op_kind), 5); done();

    cur_req = "R6";
    wr(LOCK_A, 16'h00C0); wr(LOCK_A, 16'hFFFD); chk("R6", "preg lock", 32'(op_kind), 7); done();
    wr(21'h81, 16'h00C0); wr(21'h81, 16'hFFFD); chk("R6", "wrong addr is program", 32'(op_kind), 6); done();
    wr(LOCK_A, 16'h00C0); wr(LOCK_A, 16'h1234); chk("R6", "preg program", 32'(op_kind), 6); done();

    cur_req = "R7";
    wr(0, 16'h00FF);
    wr(0, 16'h0020); wr(0, 16'h0055); chk("R7", "no req on bad confirm", 32'(op_req), 0);
    rd(); chk("R7", "seq error bits", 32'(status_q), 32'hB0);
    wr(0, 16'h00FF); wr(0, 16'h0050); chk("R7", "clear keeps mode", 32'(rd_mode), 0);
    rd(); chk("R7", "cleared", 32'(status_q), 32'h80);
    wr(0, 16'h0060); wr(0, 16'h0077); rd(); chk("R7", "lock seq error", 32'(status_q), 32'hB0);
    wr(0, 16'h0050);

    cur_req = "R12";
    @(negedge clk); rd_en = 1;
    wr(0, 16'h0020); wr(0, 16'h00D0);
    chk("R12", "held during read", 32'(status_q), 32'h80);
    @(negedge clk); rd_en = 0;
    rd(); chk("R12", "new read sees busy", 32'(status_q), 32'h00);
    done();
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule